// File: doc/BRIEF.md
# Four-Channel DMA Run Control

This block holds the run state of four DMA channels and decides, cycle by cycle, which channel may move its next word. A CPU writes byte-wide registers. Each channel has a control register with an enable flag, a start/busy flag and a sticky error flag. A shared hold register carries one freeze bit per channel. Each channel also has a word-count register. The block offers one word at a time to a transfer engine over a valid/ready stream that carries the channel number. It counts the words down and raises a one-cycle completion pulse when a channel's count runs out.

Software stops a channel by writing the control register with enable kept at 1 and start cleared. The stop does not take effect at once. The busy flag keeps reading 1 for two clocks and drops only when the channel has really gone quiet. Software must therefore poll the flag, or wait two clocks, before it clears enable. If enable is cleared while busy still reads 1, the channel is reset at once and flagged.

Stream rules: once `xfer_valid` is high, it and `xfer_chan` stay unchanged until a cycle with `xfer_ready` high. That cycle moves the word. The engine may hold `xfer_ready` low for any number of cycles. A word already offered is never withdrawn, not even by a hold bit, a stop or an abort.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset, every control register, the hold register and every count register read 0, `xfer_valid` is 0 and `irq_done` is 0.
- R2: Control register n is at address n. Bit 7 is enable, bit 6 is the error flag and bit 0 is start/busy; the other bits read 0. The count register of channel n is at address 8+n. Writing 81H to an idle channel with a nonzero count sets busy. The channel then offers exactly as many words as the count, and each accepted word lowers the count by one.
- R3: When the last word of a channel is accepted, its busy flag reads 0 after that clock edge, `irq_done[n]` is high for exactly one cycle, and enable stays 1.
- R4: Writing 80H to a busy channel keeps busy reading 1 for the two clocks after the write and 0 from then on. At most one more word is accepted after the write. No completion pulse is raised, and the remaining count stays readable.
- R5: Bit n of the hold register at address 4 freezes channel n: while it is set, the channel is not offered anew. A word already offered stays offered until accepted. Clearing the bit lets the channel continue.
- R6: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid` and `xfer_chan` hold their values.
- R7: When several channels are eligible, the lowest channel number is offered first. A single channel can move one word per clock.
- R8: Writing a control value with bit 7 clear while busy reads 1 ends the channel at once. The next read shows busy 0 and error 1, and no completion pulse is raised. Writing a value with bit 6 set clears the error flag.
- R9: A write of 1 to start is ignored when the same write clears enable, or when the channel's count is 0.
- R10: Clearing enable after busy has dropped following a stop leaves the error flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational |
| xfer_valid | output | 1 | A word is offered to the transfer engine |
| xfer_chan | output | 2 | Channel of the offered word |
| xfer_ready | input | 1 | Transfer engine accepts the offered word |
| irq_done | output | 4 | Per-channel completion pulse |

## Verification
The bound checker watches on every cycle that an offered word is held under back-pressure, and that a frozen channel is never newly offered. It also checks that a completion pulse lasts one cycle and comes with busy falling, that busy stays 1 while a stop is pending, and that an early enable clear ends the channel with its error flag set. The exact two-clock stop latency, the word counts and count readback, the priority order between channels, and the ignored start writes are shown only by the bench's scenarios, which compare register reads and accepted-word tallies against values worked out from the requirements.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;
  localparam int REG_W        = 8;
  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_ERR_BIT = 6;
  localparam int CTRL_ST_BIT  = 0;
  localparam int HOLD_ADDR    = 4;
  localparam int CNT_BASE     = 8;

  typedef struct packed {
    logic en;
    logic err;
    logic start;
    logic pend;
  } chan_stat_t;
endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_run_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STOP_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             hold,
  input  logic             presented,
  input  logic             word_done,
  output logic             req,
  output chan_stat_t       stat,
  output logic [CNT_W-1:0] count,
  output logic             done_irq
);
  localparam int AGE_W = (STOP_LAT > 1) ? $clog2(STOP_LAT) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(STOP_LAT - 1);

  logic en_q, err_q, start_q, pend_q;
  logic [AGE_W-1:0] age_q;
  logic abort, soft_stop, kick, finish, stop_ok, has_more;

  // enable cleared while busy still reads 1: immediate reset of the channel
  assign abort     = ctrl_we && !wdata[CTRL_EN_BIT] && start_q;
  assign soft_stop = ctrl_we && wdata[CTRL_EN_BIT] && !wdata[CTRL_ST_BIT] && start_q && !pend_q;
  assign kick      = ctrl_we && wdata[CTRL_EN_BIT] && wdata[CTRL_ST_BIT] && !start_q && (count != '0);
  assign finish    = word_done && start_q && (count == CNT_W'(1));
  // the stop completes once the latency has run out and no word is on offer
  assign stop_ok   = pend_q && (age_q == AGE_LAST) && !presented;
  // look ahead past the word on offer so a lone channel runs at full rate
  assign has_more  = presented ? (count > CNT_W'(1)) : (count != '0);
  assign req       = en_q && start_q && !pend_q && !hold && has_more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      start_q  <= 1'b0;
      pend_q   <= 1'b0;
      age_q    <= '0;
      count    <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (ctrl_we) en_q <= wdata[CTRL_EN_BIT];

      if (abort) err_q <= 1'b1;
      else if (ctrl_we && wdata[CTRL_ERR_BIT]) err_q <= 1'b0;

      if (cnt_we) count <= CNT_W'(wdata);
      else if (word_done && count != '0) count <= count - CNT_W'(1);

      if (abort) begin
        start_q <= 1'b0;
        pend_q  <= 1'b0;
        age_q   <= '0;
      end else if (finish) begin
        start_q  <= 1'b0;
        pend_q   <= 1'b0;
        age_q    <= '0;
        done_irq <= 1'b1;
      end else if (pend_q) begin
        if (stop_ok) begin
          start_q <= 1'b0;
          pend_q  <= 1'b0;
          age_q   <= '0;
        end else if (age_q != AGE_LAST) begin
          age_q <= age_q + AGE_W'(1);
        end
      end else if (soft_stop) begin
        pend_q <= 1'b1;
        age_q  <= '0;
      end else if (kick) begin
        start_q <= 1'b1;
      end
    end
  end

  assign stat = '{en: en_q, err: err_q, start: start_q, pend: pend_q};
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan
);
  logic [CH_W-1:0] pick;
  logic            any;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    pick = '0;
    any  = |req;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) pick = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
    end else if (!out_valid || out_ready) begin
      out_valid <= any;
      if (any) out_chan <= pick;
    end
  end
endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import dma_run_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 8,
  parameter int STOP_LAT = 2,
  parameter int ADDR_W   = 4,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              xfer_valid,
  output logic [CH_W-1:0]   xfer_chan,
  input  logic              xfer_ready,
  output logic [NUM_CH-1:0] irq_done
);
  chan_stat_t              stat [NUM_CH];
  logic [CNT_W-1:0]        cnt  [NUM_CH];
  logic [NUM_CH-1:0]       req;
  logic [NUM_CH-1:0]       hold_q;
  logic [NUM_CH-1:0]       start_vec, pend_vec, err_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(HOLD_ADDR)) hold_q <= wr_data[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic on_offer;
    assign on_offer = xfer_valid && (xfer_chan == CH_W'(g));

    dma_chan_ctl #(.CNT_W(CNT_W), .STOP_LAT(STOP_LAT)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (wr_en && wr_addr == ADDR_W'(g)),
      .cnt_we   (wr_en && wr_addr == ADDR_W'(CNT_BASE + g)),
      .wdata    (wr_data),
      .hold     (hold_q[g]),
      .presented(on_offer),
      .word_done(on_offer && xfer_ready),
      .req      (req[g]),
      .stat     (stat[g]),
      .count    (cnt[g]),
      .done_irq (irq_done[g])
    );

    assign start_vec[g] = stat[g].start;
    assign pend_vec[g]  = stat[g].pend;
    assign err_vec[g]   = stat[g].err;
  end

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .out_ready(xfer_ready),
    .out_valid(xfer_valid),
    .out_chan (xfer_chan)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(HOLD_ADDR)) rd_data = REG_W'(hold_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ADDR_W'(i)) begin
        rd_data[CTRL_EN_BIT]  = stat[i].en;
        rd_data[CTRL_ERR_BIT] = stat[i].err;
        rd_data[CTRL_ST_BIT]  = stat[i].start;
      end
      if (rd_addr == ADDR_W'(CNT_BASE + i)) rd_data = REG_W'(cnt[i]);
    end
  end
endmodule

// File: rtl/dma_run_ctrl_chk.sv
module dma_run_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wdata_en,
  input logic              xfer_valid,
  input logic [CH_W-1:0]   xfer_chan,
  input logic              xfer_ready,
  input logic [NUM_CH-1:0] irq_done,
  input logic [NUM_CH-1:0] hold_q,
  input logic [NUM_CH-1:0] start_vec,
  input logic [NUM_CH-1:0] pend_vec,
  input logic [NUM_CH-1:0] err_vec
);
  logic [NUM_CH-1:0] hold_d;
  always_ff @(posedge clk) begin
    if (!rst_n) hold_d <= '0;
    else hold_d <= hold_q;
  end

  p_offer_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_chan));

  p_hold_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid || xfer_ready) |=> (!xfer_valid || !hold_d[xfer_chan]));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done[g] |=> !irq_done[g]);

    p_irq_with_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done[g] |-> !start_vec[g] && $past(start_vec[g]));

    p_busy_while_stopping_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vec[g] |-> start_vec[g]);

    p_early_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == ADDR_W'(g) && !wdata_en && start_vec[g]
      |=> !start_vec[g] && err_vec[g] && !irq_done[g]);
  end
endmodule

bind dma_run_ctrl dma_run_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wdata_en  (wr_data[7]),
  .xfer_valid(xfer_valid),
  .xfer_chan (xfer_chan),
  .xfer_ready(xfer_ready),
  .irq_done  (irq_done),
  .hold_q    (hold_q),
  .start_vec (start_vec),
  .pend_vec  (pend_vec),
  .err_vec   (err_vec)
);

// File: tb/dma_run_ctrl_test.sv
module dma_run_ctrl_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       xfer_valid;
  logic [1:0] xfer_chan;
  logic       xfer_ready = 1'b0;
  logic [3:0] irq_done;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 1;
  int cyc = 0;
  int hs_cnt [NCH] = '{default: 0};
  int irq_cnt[NCH] = '{default: 0};
  int seq_log[2048];
  int seq_n = 0;

  dma_run_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_valid(xfer_valid), .xfer_chan(xfer_chan),
    .xfer_ready(xfer_ready), .irq_done(irq_done)
  );

  // bench-side tallies of accepted words and completion pulses
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && xfer_valid && xfer_ready) begin
      hs_cnt[xfer_chan] <= hs_cnt[xfer_chan] + 1;
      seq_log[seq_n % 2048] <= int'(xfer_chan);
      seq_n <= seq_n + 1;
    end
    for (int i = 0; i < NCH; i++)
      if (rst_n && irq_done[i]) irq_cnt[i] <= irq_cnt[i] + 1;
  end

  always @(negedge clk) begin
    if (!rst_n || rdy_mode == 0) xfer_ready <= 1'b0;
    else if (rdy_mode == 1) xfer_ready <= 1'b1;
    else xfer_ready <= ~xfer_ready;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {throttle ready, channel, word count}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 2'd0, 8'd1},  {1'b0, 2'd1, 8'd4},  {1'b1, 2'd2, 8'd7},
    {1'b0, 2'd3, 8'd2},  {1'b1, 2'd0, 8'd16}, {1'b1, 2'd3, 8'd255}
  };

  initial begin
    logic [7:0] r;
    int h0, i0, base;

    cycles(3);
    // R1: reset state
    chk("R1 valid", int'(xfer_valid), 0);
    chk("R1 irq", int'(irq_done), 0);
    rst_n = 1'b1;
    cycles(2);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), r);
      chk("R1 register", int'(r), 0);
    end
    chk("R1 valid after reset", int'(xfer_valid), 0);

    // R2 / R3: single-channel runs from the table
    for (int v = 0; v < 6; v++) begin
      int ch, n, t;
      ch = int'(VEC[v][9:8]);
      n  = int'(VEC[v][7:0]);
      rdy_mode = VEC[v][10] ? 2 : 1;
      h0 = hs_cnt[ch];
      i0 = irq_cnt[ch];
      wr(4'(8 + ch), 8'(n));
      wr(4'(ch), 8'h81);
      t = 0;
      while (irq_cnt[ch] == i0 && t < 2000) begin
        @(negedge clk);
        t++;
      end
      cycles(2);
      chk("R2 words moved", hs_cnt[ch] - h0, n);
      chk("R3 one completion pulse", irq_cnt[ch] - i0, 1);
      rd(4'(ch), r);
      chk("R3 ctrl after done", int'(r), 'h80);
      rd(4'(8 + ch), r);
      chk("R2 count drained", int'(r), 0);
    end
    rdy_mode = 1;

    // R4: soft stop latency on channel 0
    wr(4'd8, 8'd20);
    h0 = hs_cnt[0];
    i0 = irq_cnt[0];
    wr(4'd0, 8'h81);
    cycles(3);
    wr(4'd0, 8'h80);
    base = hs_cnt[0];
    rd(4'd0, r);
    chk("R4 busy first clock", int'(r[0]), 1);
    @(negedge clk);
    rd(4'd0, r);
    chk("R4 busy second clock", int'(r[0]), 1);
    @(negedge clk);
    rd(4'd0, r);
    chk("R4 busy dropped", int'(r), 'h80);
    cycles(5);
    chk("R4 at most one more word", int'(hs_cnt[0] - base <= 1), 1);
    chk("R4 no completion", irq_cnt[0] - i0, 0);
    rd(4'd8, r);
    chk("R4 count kept", int'(r), 20 - (hs_cnt[0] - h0));

    // R10: clearing enable after busy dropped
    wr(4'd0, 8'h00);
    rd(4'd0, r);
    chk("R10 no error", int'(r), 'h00);

    // R8: enable cleared while busy
    wr(4'd8, 8'd50);
    i0 = irq_cnt[0];
    wr(4'd0, 8'h81);
    cycles(3);
    wr(4'd0, 8'h00);
    rd(4'd0, r);
    chk("R8 abort reads error", int'(r), 'h40);
    cycles(3);
    base = hs_cnt[0];
    cycles(5);
    chk("R8 no further words", hs_cnt[0] - base, 0);
    chk("R8 no completion", irq_cnt[0] - i0, 0);
    wr(4'd0, 8'h40);
    rd(4'd0, r);
    chk("R8 error cleared", int'(r), 'h00);

    // R5 / R6: back-pressure and hold on channel 2
    rdy_mode = 0;
    h0 = hs_cnt[2];
    i0 = irq_cnt[2];
    wr(4'd10, 8'd3);
    wr(4'd2, 8'h81);
    cycles(4);
    chk("R6 offer held valid", int'(xfer_valid), 1);
    chk("R6 offer held chan", int'(xfer_chan), 2);
    wr(4'd4, 8'h04);
    cycles(2);
    chk("R5 offered word stays", int'(xfer_valid), 1);
    rdy_mode = 1;
    cycles(5);
    chk("R5 only held word moved", hs_cnt[2] - h0, 1);
    chk("R5 frozen, nothing offered", int'(xfer_valid), 0);
    rd(4'd4, r);
    chk("R5 hold reg readback", int'(r), 'h04);
    wr(4'd4, 8'h00);
    cycles(8);
    chk("R5 resumes to end", hs_cnt[2] - h0, 3);
    chk("R5 completion after resume", irq_cnt[2] - i0, 1);

    // R7: priority, with both channels released by one hold write
    wr(4'd4, 8'h0F);
    wr(4'd9, 8'd2);
    wr(4'd11, 8'd2);
    wr(4'd3, 8'h81);
    wr(4'd1, 8'h81);
    cycles(3);
    chk("R7 nothing while frozen", int'(xfer_valid), 0);
    base = seq_n;
    wr(4'd4, 8'h00);
    cycles(8);
    chk("R7 four words", seq_n - base, 4);
    chk("R7 order 0", seq_log[(base + 0) % 2048], 1);
    chk("R7 order 1", seq_log[(base + 1) % 2048], 1);
    chk("R7 order 2", seq_log[(base + 2) % 2048], 3);
    chk("R7 order 3", seq_log[(base + 3) % 2048], 3);

    // R9: ignored start writes
    wr(4'd11, 8'd5);
    base = hs_cnt[3];
    wr(4'd3, 8'h01);
    rd(4'd3, r);
    chk("R9 start without enable", int'(r), 'h00);
    cycles(4);
    chk("R9 no words without enable", hs_cnt[3] - base, 0);
    wr(4'd11, 8'd0);
    wr(4'd3, 8'h81);
    rd(4'd3, r);
    chk("R9 start with zero count", int'(r), 'h80);
    cycles(4);
    chk("R9 no words with zero count", hs_cnt[3] - base, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule